// File: doc/BRIEF.md
# Pipelined Synchronous SRAM Access Controller

This block wraps a word-wide internal array with the control and datapath of a pipelined synchronous SRAM. On each rising clock edge it decodes three chip selects of mixed polarity and two address strobes, one for the processor and one for the controller. It also decodes a global write enable, a byte write enable and one write select per byte lane. From these it starts read or write accesses. Read data passes through an output register, so it appears one clock after the access begins. An asynchronous output enable gates the data bus. The bus is split into an input word, an output word and a drive enable, which are joined at the pad.

Accesses launched by the controller strobe decide read or write at the launching edge, and the write data is captured at that same edge. Accesses launched by the processor strobe always launch as reads. They become writes if the write controls are active on the following edge, with no new strobe at that edge. The low address bits of an ongoing access can be replaced from an external burst counter by holding the advance input low. Deselecting the device floats the bus at once. The first cycle of an access that leaves the deselected state also keeps the bus floating, even if the output register still holds older data.

Top module: `sram_pipe_ctl`

## Requirements
- R1: The device counts as selected only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0. A recognised strobe edge that occurs while the device is not selected enters the deselected state. Reset also leaves the device deselected.
- R2: When `sel1_n`=1, a low `pstb_n` is ignored. Without a controller strobe, no access starts and the bus keeps whatever it was driving.
- R3: A read starts at an edge with a recognised strobe, the device selected, and `gwr_n`=`bwr_n`=1. From the next edge onward, `dq_o` carries the addressed word and `dq_oe`=1 while `oe_n`=0.
- R4: When both strobes are low at an edge, only the processor strobe takes effect. The write controls at that edge are ignored and the access launches as a read.
- R5: Reads started on consecutive edges each deliver their own word on consecutive cycles.
- R6: `oe_n`=1 forces `dq_oe`=0 at once, without waiting for a clock edge. Setting `oe_n` back to 0 restores the drive.
- R7: After a deselecting edge, `dq_oe`=0 immediately and stays 0 until a new access starts.
- R8: In the cycle after an access starts from the deselected state, `dq_oe`=0 regardless of `oe_n`. From the following edge the normal rules apply.
- R9: `gwr_n`=0 writes all lanes, whatever `bwr_n` and `lane_n` hold.
- R10: With `gwr_n`=1 and `bwr_n`=0, lane i (bits 8i+7:8i) is written only when `lane_n[i]`=0. With all lane selects high, this is a write cycle that changes nothing. Any write cycle floats the bus unless a read result is loaded at that same edge.
- R11: For a processor-strobe access, if no strobe is present at the next edge and the write controls are active there, the access becomes a write. The write goes to the captured address, using `dq_i` from that edge, and the bus floats.
- R12: A controller-strobe write captures `dq_i` at the strobe edge and stores it at the captured address.
- R13: An access continues when `adv_n`=0, no strobe is present and the device is not deselected. The new address is the held upper address bits joined with `burst_lo`, and the write controls at that edge decide read or write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address, sampled when a strobe starts an access |
| sel1_n | input | 1 | Chip select 1, active low; also qualifies the processor strobe |
| sel2 | input | 1 | Chip select 2, active high |
| sel3_n | input | 1 | Chip select 3, active low |
| pstb_n | input | 1 | Processor address strobe, active low |
| cstb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| burst_lo | input | BURST_W | Low address bits from the external burst counter |
| gwr_n | input | 1 | Global write, active low, all lanes |
| bwr_n | input | 1 | Byte write enable, active low |
| lane_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_i | input | LANES*LANE_W | Write data from the bus |
| dq_o | output | LANES*LANE_W | Output register contents |
| dq_oe | output | 1 | Bus drive enable |

## Verification
Two situations are the hardest to reach. The first is a processor-strobe access that turns into a write one edge later. The second is a stale output word that would leak onto the bus right after reselection.

For the first, the stimulus issues a processor strobe with the write controls idle. It then drops the strobes and raises the write controls with fresh data on the next cycle, and reads the word back afterwards.

For the second, the stimulus reads a word with the output enable held low, so the output register is valid. It then deselects the device through a strobe and starts a new read. The bench model predicts a floating bus for exactly one cycle before the new word appears.

// File: rtl/sram_pipe_pkg.sv
package sram_pipe_pkg;

   // decoded view of one clock edge
   typedef struct packed {
      logic sel;       // all three selects true
      logic strobe;    // a recognised strobe
      logic start;     // strobe while selected
      logic desel;     // strobe while not selected
      logic ps_start;  // start through the processor strobe
   } edge_evt_t;

endpackage

// File: rtl/sram_sel_decode.sv
module sram_sel_decode
   import sram_pipe_pkg::*;
(
   input  logic      sel1_n,
   input  logic      sel2,
   input  logic      sel3_n,
   input  logic      pstb_n,
   input  logic      cstb_n,
   output edge_evt_t evt
);

   logic ps_hit;

   // processor strobe only counts with select 1 true
   assign ps_hit       = ~pstb_n & ~sel1_n;
   assign evt.sel      = ~sel1_n & sel2 & ~sel3_n;
   assign evt.strobe   = ps_hit | ~cstb_n;
   assign evt.start    = evt.strobe & evt.sel;
   assign evt.desel    = evt.strobe & ~evt.sel;
   assign evt.ps_start = evt.start & ps_hit;

endmodule

// File: rtl/sram_lane_mask.sv
module sram_lane_mask #(
   parameter int LANES = 4
)(
   input  logic             gwr_n,
   input  logic             bwr_n,
   input  logic [LANES-1:0] lane_n,
   output logic             wr_req,
   output logic [LANES-1:0] mask
);

   // global write overrides the per-lane selects
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign mask[l] = ~gwr_n | (~bwr_n & ~lane_n[l]);
   end

   assign wr_req = ~gwr_n | ~bwr_n;

endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4,
   parameter int LANE_W = 8
)(
   input  logic                    clk,
   input  logic                    we,
   input  logic [ADDR_W-1:0]       waddr,
   input  logic [LANES-1:0]        wmask,
   input  logic [LANES*LANE_W-1:0] wdata,
   input  logic [ADDR_W-1:0]       raddr,
   output logic [LANES*LANE_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   for (genvar l = 0; l < LANES; l++) begin : g_bank
      logic [LANE_W-1:0] bank [DEPTH];

      always_ff @(posedge clk) begin
         if (we && wmask[l]) begin
            bank[waddr] <= wdata[l*LANE_W +: LANE_W];
         end
      end

      assign rdata[l*LANE_W +: LANE_W] = bank[raddr];
   end

endmodule

// File: rtl/sram_pipe_ctl.sv
module sram_pipe_ctl
   import sram_pipe_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int LANES   = 4,
   parameter int LANE_W  = 8,
   parameter int BURST_W = 2
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    sel1_n,
   input  logic                    sel2,
   input  logic                    sel3_n,
   input  logic                    pstb_n,
   input  logic                    cstb_n,
   input  logic                    adv_n,
   input  logic [BURST_W-1:0]      burst_lo,
   input  logic                    gwr_n,
   input  logic                    bwr_n,
   input  logic [LANES-1:0]        lane_n,
   input  logic                    oe_n,
   input  logic [LANES*LANE_W-1:0] dq_i,
   output logic [LANES*LANE_W-1:0] dq_o,
   output logic                    dq_oe
);

   localparam int DATA_W = LANES * LANE_W;
   localparam int HI_W   = ADDR_W - BURST_W;

   // elaboration checks
   if (BURST_W < 1 || BURST_W >= ADDR_W) begin : g_bad_burst
      $error("BURST_W must lie between 1 and ADDR_W-1");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("LANES and LANE_W must be positive");
   end

   edge_evt_t          evt;
   logic               wr_req;
   logic [LANES-1:0]   mask;
   logic [DATA_W-1:0]  rdata;

   logic [ADDR_W-1:0]  a_q;
   logic               rd_go_q, ps_org_q;
   logic               wr_go_q;
   logic [ADDR_W-1:0]  wa_q;
   logic [LANES-1:0]   wm_q;
   logic [DATA_W-1:0]  wd_q;
   logic [DATA_W-1:0]  out_q;
   logic               outv_q, desel_q, fresh_q;

   logic               convert, cont, new_acc, new_wr, new_rd;
   logic [ADDR_W-1:0]  acc_addr;

   sram_sel_decode u_dec (
      .sel1_n (sel1_n),
      .sel2   (sel2),
      .sel3_n (sel3_n),
      .pstb_n (pstb_n),
      .cstb_n (cstb_n),
      .evt    (evt)
   );

   sram_lane_mask #(.LANES(LANES)) u_mask (
      .gwr_n  (gwr_n),
      .bwr_n  (bwr_n),
      .lane_n (lane_n),
      .wr_req (wr_req),
      .mask   (mask)
   );

   sram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
      .clk   (clk),
      .we    (wr_go_q),
      .waddr (wa_q),
      .wmask (wm_q),
      .wdata (wd_q),
      .raddr (a_q),
      .rdata (rdata)
   );

   // processor access turns into a write one edge after its strobe
   assign convert  = rd_go_q & ps_org_q & ~evt.strobe & wr_req;
   assign cont     = ~evt.strobe & ~adv_n & ~desel_q & ~convert;
   assign acc_addr = evt.start ? addr : {a_q[ADDR_W-1 -: HI_W], burst_lo};
   assign new_acc  = evt.start | cont;
   assign new_wr   = new_acc & ~evt.ps_start & wr_req;
   assign new_rd   = new_acc & (evt.ps_start | ~wr_req);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q      <= '0;
         rd_go_q  <= 1'b0;
         ps_org_q <= 1'b0;
         wr_go_q  <= 1'b0;
         wa_q     <= '0;
         wm_q     <= '0;
         wd_q     <= '0;
         out_q    <= '0;
         outv_q   <= 1'b0;
         desel_q  <= 1'b1;
         fresh_q  <= 1'b0;
      end else begin
         rd_go_q  <= new_rd;
         ps_org_q <= evt.ps_start;
         wr_go_q  <= new_wr | convert;
         if (new_acc) a_q <= acc_addr;
         if (convert) begin
            wa_q <= a_q;
            wm_q <= mask;
            wd_q <= dq_i;
         end else if (new_wr) begin
            wa_q <= acc_addr;
            wm_q <= mask;
            wd_q <= dq_i;
         end
         if (rd_go_q && !convert) begin
            out_q  <= rdata;
            outv_q <= 1'b1;
         end else if (convert || new_wr) begin
            outv_q <= 1'b0;
         end
         if (evt.desel)      desel_q <= 1'b1;
         else if (evt.start) desel_q <= 1'b0;
         fresh_q <= evt.start & desel_q;
      end
   end

   assign dq_o  = out_q;
   assign dq_oe = outv_q & ~oe_n & ~desel_q & ~fresh_q;

   // R1
   desel_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt.strobe && !evt.sel) |=> desel_q);

   // R7
   desel_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt.desel |=> !dq_oe);

   // R8
   fresh_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt.start && desel_q) |=> !dq_oe);

   // R2
   ps_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pstb_n && sel1_n && cstb_n && adv_n && gwr_n && bwr_n)
      |=> (!rd_go_q && !wr_go_q && $stable(a_q)));

   // R9
   global_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt.start && !evt.ps_start && !gwr_n) |=> (wr_go_q && wm_q == {LANES{1'b1}}));

   // R3
   read_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_go_q && !convert) |=> outv_q);

endmodule

// File: tb/sram_pipe_ctl_tb.sv
module sram_pipe_ctl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  addr = '0;
   logic        sel1_n = 1'b1, sel2 = 1'b0, sel3_n = 1'b1;
   logic        pstb_n = 1'b1, cstb_n = 1'b1, adv_n = 1'b1;
   logic [1:0]  burst_lo = '0;
   logic        gwr_n = 1'b1, bwr_n = 1'b1;
   logic [3:0]  lane_n = 4'hF;
   logic        oe_n = 1'b0;
   logic [31:0] dq_i = '0;
   logic [31:0] dq_o;
   logic        dq_oe;

   int checks = 0;
   int errors = 0;
   string cur_req = "R7";

   // reference model state
   logic [31:0] mmem [0:255];
   logic        m_desel = 1'b1, m_fresh = 1'b0, m_outv = 1'b0;
   logic [31:0] m_out = '0;
   logic        m_rdp = 1'b0, m_psorg = 1'b0;
   logic [7:0]  m_a = '0;

   always #2 clk = ~clk;

   sram_pipe_ctl dut_i (
      .clk(clk), .rst_n(rst_n), .addr(addr), .sel1_n(sel1_n), .sel2(sel2),
      .sel3_n(sel3_n), .pstb_n(pstb_n), .cstb_n(cstb_n), .adv_n(adv_n),
      .burst_lo(burst_lo), .gwr_n(gwr_n), .bwr_n(bwr_n), .lane_n(lane_n),
      .oe_n(oe_n), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
   );

   task automatic mwrite(input logic [7:0] a);
      for (int l = 0; l < 4; l++) begin
         if (!gwr_n || (!bwr_n && !lane_n[l])) mmem[a][l*8 +: 8] = dq_i[l*8 +: 8];
      end
   endtask

   task automatic model_step();
      logic ps_hit, strobe, sel, start, des, wreq, conv, ld, cont, isps, fr;
      logic [7:0] na;
      if (!rst_n) begin
         m_desel = 1'b1; m_fresh = 1'b0; m_outv = 1'b0; m_out = '0;
         m_rdp = 1'b0; m_psorg = 1'b0; m_a = '0;
         return;
      end
      ps_hit = !pstb_n && !sel1_n;
      strobe = ps_hit || !cstb_n;
      sel    = !sel1_n && sel2 && !sel3_n;
      start  = strobe && sel;
      des    = strobe && !sel;
      wreq   = !gwr_n || !bwr_n;
      conv   = m_rdp && m_psorg && !strobe && wreq;
      ld     = m_rdp && !conv;
      if (ld) begin m_out = mmem[m_a]; m_outv = 1'b1; end
      if (conv) begin mwrite(m_a); m_outv = 1'b0; end
      cont = !strobe && !adv_n && !m_desel && !conv;
      if (start || cont) begin
         na   = start ? addr : {m_a[7:2], burst_lo};
         isps = start && ps_hit;
         if (!isps && wreq) begin
            mwrite(na);
            if (!ld) m_outv = 1'b0;
            m_rdp = 1'b0;
         end else begin
            m_rdp = 1'b1;
         end
         m_psorg = isps;
         m_a = na;
      end else begin
         m_rdp = 1'b0;
         m_psorg = 1'b0;
      end
      fr = start && m_desel;
      if (des) m_desel = 1'b1;
      else if (start) m_desel = 1'b0;
      m_fresh = fr;
   endtask

   task automatic compare();
      logic exp_oe;
      exp_oe = m_outv && !oe_n && !m_desel && !m_fresh;
      checks++;
      if (dq_oe !== exp_oe) begin
         errors++;
         $display("FAIL %s dq_oe actual %0b expected %0b", cur_req, dq_oe, exp_oe);
      end else if (exp_oe && dq_o !== m_out) begin
         errors++;
         $display("FAIL %s dq_o actual %08h expected %08h", cur_req, dq_o, m_out);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      model_step();
      #1;
      compare();
   endtask

   task automatic quiet();
      pstb_n = 1'b1; cstb_n = 1'b1; adv_n = 1'b1;
      gwr_n = 1'b1; bwr_n = 1'b1; lane_n = 4'hF;
   endtask

   task automatic select_on();
      sel1_n = 1'b0; sel2 = 1'b1; sel3_n = 1'b0;
   endtask

   task automatic c_read(input logic [7:0] a);
      quiet(); select_on(); cstb_n = 1'b0; addr = a; tick();
   endtask

   task automatic c_write(input logic [7:0] a, input logic [31:0] d,
                          input logic g, input logic b, input logic [3:0] ln);
      quiet(); select_on(); oe_n = 1'b1; cstb_n = 1'b0; addr = a; dq_i = d;
      gwr_n = g; bwr_n = b; lane_n = ln; tick();
   endtask

   task automatic idle(input int n);
      quiet();
      for (int i = 0; i < n; i++) tick();
   endtask

   initial begin
      #(200000 * 4);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // reset state: bus floats (R7)
      cur_req = "R7";
      for (int i = 0; i < 3; i++) tick();
      rst_n = 1'b1;
      tick();

      // R12 R9: preload with controller-strobe global writes
      cur_req = "R12";
      for (int i = 0; i < 16; i++) c_write(8'(i), 32'hA0B0C0D0 ^ (32'(i) * 32'h01030507), 1'b0, 1'b1, 4'hF);
      idle(1);

      // R3: single read
      cur_req = "R3";
      oe_n = 1'b0;
      c_read(8'd3);
      idle(2);

      // R5: back-to-back reads
      cur_req = "R5";
      for (int i = 0; i < 8; i++) c_read(8'(i));
      idle(2);

      // R6: asynchronous output enable
      cur_req = "R6";
      c_read(8'd6); idle(1);
      #1 oe_n = 1'b1; #1 compare();
      oe_n = 1'b0; #1 compare();
      idle(1);

      // R10: byte-lane writes
      cur_req = "R10";
      c_write(8'd5, 32'h11223344, 1'b1, 1'b0, 4'b1010);
      c_write(8'd6, 32'hDEADBEEF, 1'b1, 1'b0, 4'hF);
      oe_n = 1'b0;
      c_read(8'd5); c_read(8'd6); idle(2);

      // R9: global write overrides lane selects
      cur_req = "R9";
      c_write(8'd7, 32'hCAFEF00D, 1'b0, 1'b1, 4'hF);
      c_write(8'd10, 32'h0BADC0DE, 1'b0, 1'b0, 4'b0111);
      oe_n = 1'b0;
      c_read(8'd7); c_read(8'd10); idle(2);

      // R11: processor-strobe access turned into a write
      cur_req = "R11";
      quiet(); select_on(); pstb_n = 1'b0; addr = 8'd9; tick();
      quiet(); oe_n = 1'b1; bwr_n = 1'b0; lane_n = 4'b0000; dq_i = 32'h5A5A1234; tick();
      quiet(); oe_n = 1'b0; tick();
      c_read(8'd9); idle(2);
      // processor access that stays a read
      quiet(); select_on(); pstb_n = 1'b0; addr = 8'd2; tick();
      idle(2);

      // R4: both strobes low, write controls ignored
      cur_req = "R4";
      quiet(); select_on(); pstb_n = 1'b0; cstb_n = 1'b0; gwr_n = 1'b0;
      addr = 8'd4; dq_i = 32'hFFFFFFFF; tick();
      idle(2);
      c_read(8'd4); idle(2);

      // R2: processor strobe with select 1 false is ignored
      cur_req = "R2";
      c_read(8'd2); idle(1);
      quiet(); sel1_n = 1'b1; pstb_n = 1'b0; addr = 8'd5; tick();
      idle(2);

      // R7: deselect through controller strobe
      cur_req = "R7";
      quiet(); sel1_n = 1'b0; sel2 = 1'b0; sel3_n = 1'b0; cstb_n = 1'b0; tick();
      idle(3);

      // R8: leave deselected state with stale output data
      cur_req = "R8";
      c_read(8'd8); idle(3);

      // R1: select 3 false with processor strobe deselects
      cur_req = "R1";
      quiet(); sel1_n = 1'b0; sel2 = 1'b1; sel3_n = 1'b1; pstb_n = 1'b0; tick();
      idle(2);
      c_read(8'd1); idle(2);

      // R13: burst continuation from external counter
      cur_req = "R13";
      c_read(8'd8);
      for (int b = 1; b < 4; b++) begin
         quiet(); adv_n = 1'b0; burst_lo = 2'(b); tick();
      end
      quiet(); oe_n = 1'b1; adv_n = 1'b0; burst_lo = 2'd0; gwr_n = 1'b0;
      dq_i = 32'h76543210; tick();
      quiet(); oe_n = 1'b0; tick();
      c_read(8'd8); idle(2);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule